// File: doc/BRIEF.md
# Packed Halfword Multiply and Absolute-Difference Unit

This block is a one-stage arithmetic datapath for a SIMD pipeline. It takes two 64-bit packed operands, `in_a` and `in_b`, a 64-bit accumulator `in_acc` and a 4-bit operation code. It returns one registered 64-bit result. The operand is treated either as four 16-bit halfword lanes (lane i occupies bits 16i+15:16i) or as eight bytes (byte j occupies bits 8j+7:8j).

The operations fall into a few groups:

- Lane-wise multiplies that keep the low or the high half of each 32-bit product.
- Dot-product reductions, either pairwise into two 32-bit halves or over all four lanes.
- Sums of absolute differences over bytes or over halfwords.
- Scalar multiply-accumulate forms that add a product to `in_acc`.

A caller presents `in_valid` with the operands. Exactly one clock later it reads `out_result` while `out_valid` is high. Saturation, condition flags and instruction decode belong to neighbouring blocks.

Top module: `pmsad_unit`

## Requirements
- R1: `out_valid` equals the `in_valid` of the previous clock. A synchronous reset (`rst` high) clears both `out_valid` and `out_result` to zero.
- R2: In a cycle with `in_valid` low, `out_result` keeps its value whatever the other inputs do.
- R3: Op 0 (signed pairwise dot product). Lanes 0 and 1 of A and B are sign-extended, multiplied lane by lane and summed. The sum is truncated to 32 bits and placed in result bits 31:0. Lanes 2 and 3 are treated the same way and placed in bits 63:32.
- R4: Op 1 is the same pairwise dot product as op 0, but the halfwords are taken as unsigned.
- R5: Op 2 returns the sum of |a_j − b_j| over all eight unsigned byte pairs, zero-extended to 64 bits.
- R6: Op 3 returns the sum of |a_i − b_i| over all four unsigned halfword pairs, zero-extended to 64 bits.
- R7: Op 4 (signed) and op 5 (unsigned) place bits 15:0 of each lane product in that lane of the result.
- R8: Op 6 places bits 31:16 of each signed lane product in that lane of the result.
- R9: Op 7 places bits 31:16 of each unsigned lane product in that lane of the result.
- R10: Op 8 returns the sum of the four signed lane products, sign-extended to 64 bits. Op 9 returns the sum of the four unsigned lane products, zero-extended to 64 bits.
- R11: Op 10 returns `in_acc` plus the signed product of A[31:0] and B[31:0], modulo 2^64.
- R12: Op 11 returns `in_acc` plus the signed lane-0 product plus the signed lane-1 product, modulo 2^64. Op 12 returns `in_acc` plus only the signed lane-0 product.
- R13: Ops 13, 14 and 15 return a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation request strobe |
| in_op | input | 4 | Operation code (0 to 12 defined) |
| in_a | input | 64 | Packed operand A |
| in_b | input | 64 | Packed operand B |
| in_acc | input | 64 | Scalar accumulator for ops 10 to 12 |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| out_result | output | 64 | Registered result |

## Verification
The bench builds the unit with its default widths: 64-bit operands, 16-bit halfword lanes and 8-bit bytes. At these widths every sign boundary of interest can be hit directly:

- Lanes of 0x8000 make the pairwise sum reach exactly 2^31, which wraps in the 32-bit half.
- All-ones unsigned lanes push the high-half product to 0xFFFE.
- Opposite extreme bytes give the largest byte SAD of 2040.
- An accumulator near 2^64 exposes the wrap of the scalar forms.

Idle cycles with changing inputs, back-to-back requests and the unused codes are mixed into a long stream of varied operations.

// File: rtl/pmsad_pkg.sv
package pmsad_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_PAIR_S  = 4'd0,
    OP_PAIR_U  = 4'd1,
    OP_SAD_B   = 4'd2,
    OP_SAD_H   = 4'd3,
    OP_MULLO_S = 4'd4,
    OP_MULLO_U = 4'd5,
    OP_MULHI_S = 4'd6,
    OP_MULHI_U = 4'd7,
    OP_DOT4_S  = 4'd8,
    OP_DOT4_U  = 4'd9,
    OP_ACC_W   = 4'd10,
    OP_ACC_H2  = 4'd11,
    OP_ACC_H1  = 4'd12
  } pmsad_op_e;

  localparam logic [OP_W-1:0] OP_LAST = 4'd12;
endpackage

// File: rtl/pmsad_lane_mul.sv
module pmsad_lane_mul #(
  parameter int HALF_W = 16,
  localparam int PW = 2*HALF_W + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sign_en,
  input  logic [HALF_W-1:0]    a,
  input  logic [HALF_W-1:0]    b,
  output logic signed [PW-1:0] prod
);
  // one extra bit lets one signed multiplier serve both signed and unsigned lanes
  function automatic logic [HALF_W:0] widen(logic [HALF_W-1:0] x, logic s);
    return {s & x[HALF_W-1], x};
  endfunction

  logic [HALF_W:0] a_x, b_x;
  assign a_x  = widen(a, sign_en);
  assign b_x  = widen(b, sign_en);
  assign prod = $signed(a_x) * $signed(b_x);

  // a zero operand must give a zero lane product in every mode
  assert_zero_operand_R7: assert property (@(posedge clk) disable iff (rst)
    ((a == '0) || (b == '0)) |-> (prod == '0));
endmodule

// File: rtl/pmsad_sad.sv
module pmsad_sad #(
  parameter int DATA_W = 64,
  parameter int HALF_W = 16,
  parameter int BYTE_W = 8,
  localparam int NB   = DATA_W / BYTE_W,
  localparam int NH   = DATA_W / HALF_W,
  localparam int BS_W = BYTE_W + $clog2(NB),
  localparam int HS_W = HALF_W + $clog2(NH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [BS_W-1:0]   sad_byte,
  output logic [HS_W-1:0]   sad_half
);
  function automatic logic [BYTE_W-1:0] adiff_b(logic [BYTE_W-1:0] x, logic [BYTE_W-1:0] y);
    return (x > y) ? (x - y) : (y - x);
  endfunction

  function automatic logic [HALF_W-1:0] adiff_h(logic [HALF_W-1:0] x, logic [HALF_W-1:0] y);
    return (x > y) ? (x - y) : (y - x);
  endfunction

  logic [BYTE_W-1:0] bdiff [NB];
  logic [HALF_W-1:0] hdiff [NH];

  for (genvar j = 0; j < NB; j++) begin : g_byte
    assign bdiff[j] = adiff_b(a[j*BYTE_W +: BYTE_W], b[j*BYTE_W +: BYTE_W]);
  end
  for (genvar i = 0; i < NH; i++) begin : g_half
    assign hdiff[i] = adiff_h(a[i*HALF_W +: HALF_W], b[i*HALF_W +: HALF_W]);
  end

  always_comb begin
    sad_byte = '0;
    for (int j = 0; j < NB; j++) sad_byte = sad_byte + BS_W'(bdiff[j]);
    sad_half = '0;
    for (int i = 0; i < NH; i++) sad_half = sad_half + HS_W'(hdiff[i]);
  end

  // identical operands leave nothing to accumulate
  assert_equal_sad_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (a == b) |-> (sad_byte == '0 && sad_half == '0));
endmodule

// File: rtl/pmsad_acc.sv
module pmsad_acc #(
  parameter int DATA_W = 64,
  parameter int HALF_W = 16,
  localparam int PW     = 2*HALF_W + 2,
  localparam int WORD_W = 2*HALF_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pmsad_pkg::pmsad_op_e op,
  input  logic [DATA_W-1:0]    acc,
  input  logic [WORD_W-1:0]    a_w,
  input  logic [WORD_W-1:0]    b_w,
  input  logic signed [PW-1:0] lp0,
  input  logic signed [PW-1:0] lp1,
  output logic [DATA_W-1:0]    acc_sum
);
  import pmsad_pkg::*;

  function automatic logic [DATA_W-1:0] sext_p(logic signed [PW-1:0] x);
    return {{(DATA_W-PW){x[PW-1]}}, x};
  endfunction

  logic signed [2*WORD_W-1:0] wprod;
  logic [DATA_W-1:0] addend;

  assign wprod = $signed(a_w) * $signed(b_w);

  always_comb begin
    unique case (op)
      OP_ACC_W:  addend = DATA_W'(wprod);
      OP_ACC_H2: addend = sext_p(lp0) + sext_p(lp1);
      default:   addend = sext_p(lp0);
    endcase
  end

  assign acc_sum = acc + addend;

  // single-lane form with a zero low halfword must return the accumulator untouched
  assert_acc_passthru_R12: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ACC_H1 && a_w[HALF_W-1:0] == '0) |-> (acc_sum == acc));
endmodule

// File: rtl/pmsad_unit.sv
module pmsad_unit #(
  parameter int DATA_W = 64,
  parameter int HALF_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [DATA_W-1:0] in_acc,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result
);
  import pmsad_pkg::*;

  localparam int NH     = DATA_W / HALF_W;
  localparam int NB     = DATA_W / BYTE_W;
  localparam int NPAIR  = NH / 2;
  localparam int PW     = 2*HALF_W + 2;
  localparam int WORD_W = 2*HALF_W;
  localparam int BS_W   = BYTE_W + $clog2(NB);
  localparam int HS_W   = HALF_W + $clog2(NH);

  function automatic logic [DATA_W-1:0] sext_p(logic signed [PW-1:0] x);
    return {{(DATA_W-PW){x[PW-1]}}, x};
  endfunction

  pmsad_op_e op;
  logic      sign_en;
  assign op      = pmsad_op_e'(in_op);
  assign sign_en = (op == OP_PAIR_S)  || (op == OP_MULLO_S) || (op == OP_MULHI_S) ||
                   (op == OP_DOT4_S)  || (op == OP_ACC_H2)  || (op == OP_ACC_H1);

  logic signed [PW-1:0] prod [NH];
  for (genvar i = 0; i < NH; i++) begin : g_lane
    pmsad_lane_mul #(.HALF_W(HALF_W)) u_mul (
      .clk    (clk),
      .rst    (rst),
      .sign_en(sign_en),
      .a      (in_a[i*HALF_W +: HALF_W]),
      .b      (in_b[i*HALF_W +: HALF_W]),
      .prod   (prod[i])
    );
  end

  logic [WORD_W-1:0] pair_sum [NPAIR];
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic signed [PW-1:0] psum;
    assign psum        = prod[2*p] + prod[2*p+1];
    assign pair_sum[p] = psum[WORD_W-1:0];
  end

  logic [DATA_W-1:0] dot_all;
  always_comb begin
    dot_all = '0;
    for (int i = 0; i < NH; i++) dot_all = dot_all + sext_p(prod[i]);
  end

  logic [BS_W-1:0] sad_byte;
  logic [HS_W-1:0] sad_half;
  pmsad_sad #(.DATA_W(DATA_W), .HALF_W(HALF_W), .BYTE_W(BYTE_W)) u_sad (
    .clk     (clk),
    .rst     (rst),
    .a       (in_a),
    .b       (in_b),
    .sad_byte(sad_byte),
    .sad_half(sad_half)
  );

  logic [DATA_W-1:0] acc_sum;
  pmsad_acc #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .acc    (in_acc),
    .a_w    (in_a[WORD_W-1:0]),
    .b_w    (in_b[WORD_W-1:0]),
    .lp0    (prod[0]),
    .lp1    (prod[1]),
    .acc_sum(acc_sum)
  );

  logic [DATA_W-1:0] nxt;
  always_comb begin
    nxt = '0;
    case (op)
      OP_PAIR_S, OP_PAIR_U:
        for (int p = 0; p < NPAIR; p++) nxt[p*WORD_W +: WORD_W] = pair_sum[p];
      OP_SAD_B: nxt = DATA_W'(sad_byte);
      OP_SAD_H: nxt = DATA_W'(sad_half);
      OP_MULLO_S, OP_MULLO_U:
        for (int i = 0; i < NH; i++) nxt[i*HALF_W +: HALF_W] = prod[i][HALF_W-1:0];
      OP_MULHI_S, OP_MULHI_U:
        for (int i = 0; i < NH; i++) nxt[i*HALF_W +: HALF_W] = prod[i][WORD_W-1:HALF_W];
      OP_DOT4_S, OP_DOT4_U: nxt = dot_all;
      OP_ACC_W, OP_ACC_H2, OP_ACC_H1: nxt = acc_sum;
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= nxt;
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_drops_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result));
  assert_unused_zero_R13: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op > OP_LAST) |=> (out_result == '0));
endmodule

// File: tb/pmsad_unit_bench.sv
module pmsad_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  in_op = '0;
  logic [63:0] in_a = '0, in_b = '0, in_acc = '0;
  logic        out_valid;
  logic [63:0] out_result;

  int checks = 0;
  int errors = 0;
  logic        exp_valid = 1'b0;
  logic [63:0] exp_res = '0;

  always #2 clk = ~clk;  // 250 MHz

  pmsad_unit u_pmsad_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_acc(in_acc),
    .out_valid(out_valid), .out_result(out_result)
  );

  function automatic longint sh(logic [63:0] x, int i);
    return longint'($signed(x[i*16 +: 16]));
  endfunction
  function automatic longint uh(logic [63:0] x, int i);
    return longint'(x[i*16 +: 16]);
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4, 5: return "R7";
      6: return "R8";
      7: return "R9";
      8, 9: return "R10";
      10: return "R11";
      11, 12: return "R12";
      default: return "R13";
    endcase
  endfunction

  function automatic logic [63:0] ref_calc(int op, logic [63:0] a, logic [63:0] b, logic [63:0] acc);
    logic [63:0] r = '0;
    longint s = 0;
    longint d;
    case (op)
      0, 1: for (int p = 0; p < 2; p++) begin
        if (op == 0) s = sh(a,2*p)*sh(b,2*p) + sh(a,2*p+1)*sh(b,2*p+1);
        else         s = uh(a,2*p)*uh(b,2*p) + uh(a,2*p+1)*uh(b,2*p+1);
        r[p*32 +: 32] = 32'(s);
      end
      2: begin
        for (int j = 0; j < 8; j++) begin
          d = longint'(a[j*8 +: 8]) - longint'(b[j*8 +: 8]);
          s += (d < 0) ? -d : d;
        end
        r = 64'(s);
      end
      3: begin
        for (int i = 0; i < 4; i++) begin
          d = uh(a,i) - uh(b,i);
          s += (d < 0) ? -d : d;
        end
        r = 64'(s);
      end
      4, 5: for (int i = 0; i < 4; i++) r[i*16 +: 16] = 16'(uh(a,i)*uh(b,i));
      6: for (int i = 0; i < 4; i++) r[i*16 +: 16] = 16'((sh(a,i)*sh(b,i)) >>> 16);
      7: for (int i = 0; i < 4; i++) r[i*16 +: 16] = 16'((uh(a,i)*uh(b,i)) >> 16);
      8: begin for (int i = 0; i < 4; i++) s += sh(a,i)*sh(b,i); r = 64'(s); end
      9: begin for (int i = 0; i < 4; i++) s += uh(a,i)*uh(b,i); r = 64'(s); end
      10: r = acc + 64'(longint'($signed(a[31:0])) * longint'($signed(b[31:0])));
      11: r = acc + 64'(sh(a,0)*sh(b,0) + sh(a,1)*sh(b,1));
      12: r = acc + 64'(sh(a,0)*sh(b,0));
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, model the register at posedge, compare at the next negedge
  task automatic step(logic v, int op, logic [63:0] a, logic [63:0] b, logic [63:0] acc);
    string tag;
    in_valid = v; in_op = 4'(op); in_a = a; in_b = b; in_acc = acc;
    @(posedge clk);
    if (rst) begin
      exp_valid = 1'b0; exp_res = '0; tag = "R1";
    end else begin
      exp_valid = v;
      if (v) begin exp_res = ref_calc(op, a, b, acc); tag = tag_of(op); end
      else tag = "R2";
    end
    @(negedge clk);
    check("R1", {63'd0, out_valid}, {63'd0, exp_valid});
    check(tag, out_result, exp_res);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // reset state, R1
    step(1'b1, 8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 64'd5);
    step(1'b0, 0, '0, '0, '0);
    rst = 1'b0;
    // R3 / R4: 0x8000 lanes reach 2^31 per half
    step(1'b1, 0, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, '0);
    step(1'b1, 0, 64'h0003_FFFF_0002_0005, 64'h0004_0002_FFFD_0007, '0);
    step(1'b1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, '0);
    // R5 / R6: extreme and equal operands
    step(1'b1, 2, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, '0);
    step(1'b1, 2, 64'h0102_0304_0506_0708, 64'h0102_0304_0506_0708, '0);
    step(1'b1, 3, 64'hFFFF_0000_1234_0001, 64'h0000_FFFF_0034_0002, '0);
    // R7..R9: lane products, signed vs unsigned high halves
    step(1'b1, 4, 64'h8000_7FFF_FFFF_0102, 64'h8000_7FFF_0002_0304, '0);
    step(1'b1, 5, 64'h8000_7FFF_FFFF_0102, 64'h8000_7FFF_0002_0304, '0);
    step(1'b1, 6, 64'h8000_7FFF_FFFF_0102, 64'h8000_8000_0002_0304, '0);
    step(1'b1, 7, 64'hFFFF_7FFF_FFFF_0102, 64'hFFFF_8000_0002_0304, '0);
    // R10: full reduction, negative and large unsigned
    step(1'b1, 8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, '0);
    step(1'b1, 9, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, '0);
    // R11 / R12: accumulator wrap and sign
    step(1'b1, 10, 64'h0_8000_0000, 64'h0_7FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFF0);
    step(1'b1, 10, 64'h0_FFFF_FFFF, 64'h0_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    step(1'b1, 11, 64'h1111_2222_8000_FFFF, 64'h3333_4444_8000_0002, 64'd100);
    step(1'b1, 12, 64'h1111_2222_8000_FFFF, 64'h3333_4444_8000_0002, 64'd100);
    // R2: idle with moving inputs must hold
    step(1'b0, 9, 64'hDEAD_BEEF_0000_0001, 64'h1, '0);
    step(1'b0, 3, 64'h5555_AAAA_5555_AAAA, 64'h0, '0);
    // R13: unused codes
    step(1'b1, 13, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd7);
    step(1'b1, 15, 64'h1, 64'h1, 64'd7);
    // mixed stream
    for (int k = 0; k < 600; k++) begin
      step(($urandom % 4) != 0, int'($urandom % 16),
           {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule